// File: doc/BRIEF.md
# Multi-transfer DMA chunk sequencer

This block accepts DMA transfers, each described by a start byte address, a byte length and a direction flag. It keeps several of them in flight together. Every accepted transfer gets a slot in a small table. The slot is identified by the line address of the transfer's start byte. The block cuts each transfer into chunks that never cross a line boundary. A transfer has at most one chunk outstanding at a time. When several transfers are waiting to issue, the lowest-numbered slot issues first, one chunk per clock.

A downstream controller answers each chunk with a callback that carries the slot's line key. The callback catches up the completed-byte count with the issued-byte count. If the transfer is then finished, the block frees the slot and emits a completion pulse. Otherwise the transfer becomes eligible to issue its next chunk. For reads, every callback also produces a copy descriptor. The descriptor tells the packet-buffer logic where the returned line bytes go. Admission is answered one cycle after the request, with one of three status codes. A callback that matches no chunk in flight raises a sticky error flag.

Top module: `dma_multi_seq`

## Requirements
- R1: A request made while the outstanding count equals MAX_OUT gets status code 1 (full) one cycle later and creates no slot. This check takes precedence over the alias check.
- R2: A request whose start line (address >> log2(LINE_BYTES)) equals the key of a live slot gets status code 2 (aliased), and the outstanding count does not change.
- R3: An accepted request gets status code 0 one cycle later, and the outstanding count rises by one on that same edge.
- R4: The first chunk of a transfer appears one cycle after acceptance. Its address is the start address and its length is min(length, LINE_BYTES − offset), where offset = address & (LINE_BYTES−1).
- R5: Each later chunk starts at start + bytes issued, which is line aligned, and has length min(LINE_BYTES, remaining bytes). A transfer never has a second chunk issued before the callback for its current chunk.
- R6: After a callback that does not finish its transfer, the next chunk for that transfer appears exactly two cycles after the callback. No chunk appears in between.
- R7: A callback that brings the completed bytes up to the length pulses done one cycle later with the start address, length and direction. On the same edge the outstanding count falls by one and the slot's line becomes free for a new request.
- R8: For a read, each callback pulses a copy descriptor one cycle later. Its buffer position is the bytes completed before the callback. Its line offset is the start offset on the first chunk and 0 afterwards. Its length is the chunk length. Writes produce no descriptor.
- R9: A callback whose key matches no slot with a chunk in flight sets cb_err, which then stays set until reset. Such a callback changes no count and produces no done or copy pulse.
- R10: busy is high exactly when the outstanding count is nonzero. After reset, busy is low, the count is 0 and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New transfer request this cycle |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte length (must be at least 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| adm_valid | output | 1 | Admission status valid |
| adm_code | output | 2 | 0 accepted, 1 full, 2 aliased |
| chunk_valid | output | 1 | Chunk issued this cycle |
| chunk_addr | output | AW | Chunk byte address |
| chunk_len | output | LW | Chunk byte length |
| chunk_write | output | 1 | Chunk direction |
| chunk_key | output | AW−log2(LINE_BYTES) | Slot key to return on the callback |
| cb_valid | input | 1 | Chunk callback (data or ack) |
| cb_key | input | AW−log2(LINE_BYTES) | Key of the answered slot |
| copy_valid | output | 1 | Read data copy descriptor valid |
| copy_buf_pos | output | LW | Destination byte position in the transfer buffer |
| copy_line_off | output | log2(LINE_BYTES) | Source byte offset within the returned line |
| copy_len | output | LW | Bytes to copy |
| done_valid | output | 1 | Transfer finished |
| done_addr | output | AW | Start address of the finished transfer |
| done_len | output | LW | Length of the finished transfer |
| done_write | output | 1 | Direction of the finished transfer |
| busy | output | 1 | Any transfer outstanding |
| outstanding | output | log2(MAX_OUT+1) | Number of live slots |
| cb_err | output | 1 | Sticky unmatched-callback flag |

## Verification
The bench builds the block with 8-byte lines, four slots, 12-bit addresses and 8-bit lengths. With this configuration it can run a transfer from every one of the eight in-line offsets for every length from 1 to 20 bytes. That covers the single-chunk, exact-fit and three-line cases, and it covers first-chunk copy offsets in every position. Four slots make the full condition reachable with a handful of requests. The same setup checks that full wins over alias, that a freed line is accepted again, and that an unmatched callback leaves the table untouched.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    typedef enum logic [1:0] {
        ADM_OK    = 2'd0,
        ADM_FULL  = 2'd1,
        ADM_ALIAS = 2'd2
    } adm_code_e;
endpackage

// File: rtl/dseq_pick.sv
// Lowest-index set bit finder.
module dseq_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/dseq_match.sv
// Key comparison across all live slots.
module dseq_match #(
    parameter int N  = 4,
    parameter int KW = 8,
    parameter int IW = 2
) (
    input  logic [N-1:0]         live,
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [KW-1:0]        probe,
    output logic                 hit,
    output logic [IW-1:0]        hit_idx
);
    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = live[g] && (keys[g] == probe);
    end

    dseq_pick #(.N(N), .IW(IW)) u_pick (
        .vec   (eq),
        .found (hit),
        .idx   (hit_idx)
    );
endmodule

// File: rtl/dseq_chunker.sv
// Address and length of the next chunk of one transfer.
module dseq_chunker #(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int LINE_BYTES = 64
) (
    input  logic [AW-1:0] base,
    input  logic [LW-1:0] total,
    input  logic [LW-1:0] issued,
    output logic [AW-1:0] c_addr,
    output logic [LW-1:0] c_len
);
    localparam int OFFW = $clog2(LINE_BYTES);

    logic [LW:0]   room;
    logic [LW-1:0] rem;

    always_comb begin
        rem = total - issued;
        if (issued == '0) begin
            room = (LW+1)'(LINE_BYTES) - (LW+1)'(base[OFFW-1:0]);
        end else begin
            room = (LW+1)'(LINE_BYTES);
        end
        c_len  = ({1'b0, rem} < room) ? rem : room[LW-1:0];
        c_addr = base + AW'(issued);
    end
endmodule

// File: rtl/dma_multi_seq.sv
module dma_multi_seq #(
    parameter int AW         = 32,
    parameter int LW         = 16,
    parameter int LINE_BYTES = 64,
    parameter int MAX_OUT    = 64
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               req_valid,
    input  logic [AW-1:0]                      req_addr,
    input  logic [LW-1:0]                      req_len,
    input  logic                               req_write,
    output logic                               adm_valid,
    output logic [1:0]                         adm_code,
    output logic                               chunk_valid,
    output logic [AW-1:0]                      chunk_addr,
    output logic [LW-1:0]                      chunk_len,
    output logic                               chunk_write,
    output logic [AW-$clog2(LINE_BYTES)-1:0]   chunk_key,
    input  logic                               cb_valid,
    input  logic [AW-$clog2(LINE_BYTES)-1:0]   cb_key,
    output logic                               copy_valid,
    output logic [LW-1:0]                      copy_buf_pos,
    output logic [$clog2(LINE_BYTES)-1:0]      copy_line_off,
    output logic [LW-1:0]                      copy_len,
    output logic                               done_valid,
    output logic [AW-1:0]                      done_addr,
    output logic [LW-1:0]                      done_len,
    output logic                               done_write,
    output logic                               busy,
    output logic [$clog2(MAX_OUT+1)-1:0]       outstanding,
    output logic                               cb_err
);
    import dseq_pkg::*;

    localparam int OFFW = $clog2(LINE_BYTES);
    localparam int KW   = AW - OFFW;
    localparam int IW   = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;
    localparam int CW   = $clog2(MAX_OUT + 1);

    typedef struct packed {
        logic          vld;
        logic          fly;
        logic          wr;
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic [LW-1:0] iss;
        logic [LW-1:0] cmp;
    } slot_t;

    typedef struct packed {
        slot_t [MAX_OUT-1:0] slot;
        logic [CW-1:0]       cnt;
        logic                err;
        logic                adm_v;
        logic [1:0]          adm_c;
        logic                ck_v;
        logic [AW-1:0]       ck_addr;
        logic [LW-1:0]       ck_len;
        logic                ck_wr;
        logic [KW-1:0]       ck_key;
        logic                cp_v;
        logic [LW-1:0]       cp_pos;
        logic [OFFW-1:0]     cp_off;
        logic [LW-1:0]       cp_len;
        logic                dn_v;
        logic [AW-1:0]       dn_addr;
        logic [LW-1:0]       dn_len;
        logic                dn_wr;
    } state_t;

    state_t st_d, st_q;

    logic [MAX_OUT-1:0]         live_vec, wait_vec, free_vec;
    logic [MAX_OUT-1:0][KW-1:0] key_vec;

    for (genvar g = 0; g < MAX_OUT; g++) begin : g_slot
        assign live_vec[g] = st_q.slot[g].vld;
        assign wait_vec[g] = st_q.slot[g].vld && !st_q.slot[g].fly;
        assign free_vec[g] = !st_q.slot[g].vld;
        assign key_vec[g]  = st_q.slot[g].base[AW-1:OFFW];
    end

    logic          req_hit, cb_hit, iss_found, free_found;
    logic [IW-1:0] req_idx, cb_idx, iss_idx, free_idx;

    dseq_match #(.N(MAX_OUT), .KW(KW), .IW(IW)) u_req_match (
        .live    (live_vec),
        .keys    (key_vec),
        .probe   (req_addr[AW-1:OFFW]),
        .hit     (req_hit),
        .hit_idx (req_idx)
    );

    dseq_match #(.N(MAX_OUT), .KW(KW), .IW(IW)) u_cb_match (
        .live    (live_vec),
        .keys    (key_vec),
        .probe   (cb_key),
        .hit     (cb_hit),
        .hit_idx (cb_idx)
    );

    dseq_pick #(.N(MAX_OUT), .IW(IW)) u_issue_pick (
        .vec   (wait_vec),
        .found (iss_found),
        .idx   (iss_idx)
    );

    dseq_pick #(.N(MAX_OUT), .IW(IW)) u_free_pick (
        .vec   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    logic [AW-1:0] nx_addr;
    logic [LW-1:0] nx_len;

    dseq_chunker #(.AW(AW), .LW(LW), .LINE_BYTES(LINE_BYTES)) u_chunker (
        .base   (st_q.slot[iss_idx].base),
        .total  (st_q.slot[iss_idx].len),
        .issued (st_q.slot[iss_idx].iss),
        .c_addr (nx_addr),
        .c_len  (nx_len)
    );

    logic  inc, dec;
    slot_t cs;

    always_comb begin
        st_d       = st_q;
        st_d.adm_v = 1'b0;
        st_d.ck_v  = 1'b0;
        st_d.cp_v  = 1'b0;
        st_d.dn_v  = 1'b0;
        inc        = 1'b0;
        dec        = 1'b0;
        cs         = st_q.slot[cb_idx];

        // callback: catch up completed bytes, then finish or re-arm
        if (cb_valid) begin
            if (!cb_hit || !cs.fly) begin
                st_d.err = 1'b1;
            end else begin
                st_d.slot[cb_idx].cmp = cs.iss;
                st_d.slot[cb_idx].fly = 1'b0;
                if (!cs.wr) begin
                    st_d.cp_v   = 1'b1;
                    st_d.cp_pos = cs.cmp;
                    st_d.cp_off = (cs.cmp == '0) ? cs.base[OFFW-1:0] : '0;
                    st_d.cp_len = cs.iss - cs.cmp;
                end
                if (cs.iss == cs.len) begin
                    st_d.slot[cb_idx].vld = 1'b0;
                    st_d.dn_v    = 1'b1;
                    st_d.dn_addr = cs.base;
                    st_d.dn_len  = cs.len;
                    st_d.dn_wr   = cs.wr;
                    dec          = 1'b1;
                end
            end
        end

        // issue: lowest waiting slot sends its next chunk
        if (iss_found) begin
            st_d.ck_v                = 1'b1;
            st_d.ck_addr             = nx_addr;
            st_d.ck_len              = nx_len;
            st_d.ck_wr               = st_q.slot[iss_idx].wr;
            st_d.ck_key              = key_vec[iss_idx];
            st_d.slot[iss_idx].iss   = st_q.slot[iss_idx].iss + nx_len;
            st_d.slot[iss_idx].fly   = 1'b1;
        end

        // admission: full beats alias
        if (req_valid) begin
            st_d.adm_v = 1'b1;
            if (st_q.cnt == CW'(MAX_OUT)) begin
                st_d.adm_c = ADM_FULL;
            end else if (req_hit) begin
                st_d.adm_c = ADM_ALIAS;
            end else if (free_found) begin
                st_d.adm_c = ADM_OK;
                st_d.slot[free_idx].vld  = 1'b1;
                st_d.slot[free_idx].fly  = 1'b0;
                st_d.slot[free_idx].wr   = req_write;
                st_d.slot[free_idx].base = req_addr;
                st_d.slot[free_idx].len  = req_len;
                st_d.slot[free_idx].iss  = '0;
                st_d.slot[free_idx].cmp  = '0;
                inc = 1'b1;
            end else begin
                st_d.adm_c = ADM_FULL;
            end
        end

        st_d.cnt = st_q.cnt + CW'(inc) - CW'(dec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign adm_valid     = st_q.adm_v;
    assign adm_code      = st_q.adm_c;
    assign chunk_valid   = st_q.ck_v;
    assign chunk_addr    = st_q.ck_addr;
    assign chunk_len     = st_q.ck_len;
    assign chunk_write   = st_q.ck_wr;
    assign chunk_key     = st_q.ck_key;
    assign copy_valid    = st_q.cp_v;
    assign copy_buf_pos  = st_q.cp_pos;
    assign copy_line_off = st_q.cp_off;
    assign copy_len      = st_q.cp_len;
    assign done_valid    = st_q.dn_v;
    assign done_addr     = st_q.dn_addr;
    assign done_len      = st_q.dn_len;
    assign done_write    = st_q.dn_wr;
    assign busy          = (st_q.cnt != '0);
    assign outstanding   = st_q.cnt;
    assign cb_err        = st_q.err;

    // R1: the table never holds more than MAX_OUT transfers
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CW'(MAX_OUT));

    // R1: a request against a full table is refused as full
    p_full_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && outstanding == CW'(MAX_OUT)) |=> (adm_valid && adm_code == ADM_FULL));

    // R2: an aliased request creates no slot
    p_alias_keeps_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_hit && outstanding != CW'(MAX_OUT) && !cb_valid)
        |=> (adm_code == ADM_ALIAS && outstanding == $past(outstanding)));

    // R4: a chunk never crosses a line boundary and is never empty
    p_chunk_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        chunk_valid |-> (chunk_len != '0 &&
            ({1'b0, chunk_len} + (LW+1)'(chunk_addr[OFFW-1:0]) <= (LW+1)'(LINE_BYTES))));

    // R7: a completion without a same-edge acceptance lowers the count
    p_done_drops_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !(adm_valid && adm_code == ADM_OK))
        |-> (outstanding == $past(outstanding) - 1'b1));

    // R9: the error flag stays set
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cb_err |=> cb_err);

    // R8: a copy descriptor always moves at least one byte
    p_copy_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        copy_valid |-> (copy_len != '0));
endmodule

// File: tb/tb_dma_multi_seq.sv
module tb_dma_multi_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int LW   = 8;
    localparam int LINE = 8;
    localparam int MAXO = 4;
    localparam int OFFW = 3;
    localparam int KW   = AW - OFFW;
    localparam int CW   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic            req_valid = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [LW-1:0]   req_len = '0;
    logic            req_write = 1'b0;
    logic            adm_valid;
    logic [1:0]      adm_code;
    logic            chunk_valid;
    logic [AW-1:0]   chunk_addr;
    logic [LW-1:0]   chunk_len;
    logic            chunk_write;
    logic [KW-1:0]   chunk_key;
    logic            cb_valid = 1'b0;
    logic [KW-1:0]   cb_key = '0;
    logic            copy_valid;
    logic [LW-1:0]   copy_buf_pos;
    logic [OFFW-1:0] copy_line_off;
    logic [LW-1:0]   copy_len;
    logic            done_valid;
    logic [AW-1:0]   done_addr;
    logic [LW-1:0]   done_len;
    logic            done_write;
    logic            busy;
    logic [CW-1:0]   outstanding;
    logic            cb_err;

    dma_multi_seq #(.AW(AW), .LW(LW), .LINE_BYTES(LINE), .MAX_OUT(MAXO)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_write(req_write),
        .adm_valid(adm_valid), .adm_code(adm_code),
        .chunk_valid(chunk_valid), .chunk_addr(chunk_addr), .chunk_len(chunk_len),
        .chunk_write(chunk_write), .chunk_key(chunk_key),
        .cb_valid(cb_valid), .cb_key(cb_key),
        .copy_valid(copy_valid), .copy_buf_pos(copy_buf_pos),
        .copy_line_off(copy_line_off), .copy_len(copy_len),
        .done_valid(done_valid), .done_addr(done_addr), .done_len(done_len),
        .done_write(done_write),
        .busy(busy), .outstanding(outstanding), .cb_err(cb_err)
    );

    int vecs = 0;
    int bad  = 0;

    task automatic chk(string tag, int act, int exp);
        vecs++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(int addr, int len, bit wr);
        req_valid = 1'b1;
        req_addr  = AW'(addr);
        req_len   = LW'(len);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic callback(int key);
        cb_valid = 1'b1;
        cb_key   = KW'(key);
        @(negedge clk);
        cb_valid = 1'b0;
    endtask

    task automatic run_xfer(int addr, int len, bit wr);
        int off, iss, cmp, clen, exp_len;
        off = addr % LINE;
        iss = 0;
        cmp = 0;
        send(addr, len, wr);
        chk("R3 adm_valid", int'(adm_valid), 1);
        chk("R3 adm_code ok", int'(adm_code), 0);
        chk("R3 count", int'(outstanding), 1);
        chk("R10 busy", int'(busy), 1);
        while (cmp < len) begin
            @(negedge clk);
            if (iss == 0) exp_len = (len < LINE - off) ? len : LINE - off;
            else          exp_len = (len - iss < LINE) ? len - iss : LINE;
            chk(iss == 0 ? "R4 chunk_valid" : "R5 chunk_valid", int'(chunk_valid), 1);
            chk(iss == 0 ? "R4 chunk_addr" : "R5 chunk_addr", int'(chunk_addr), addr + iss);
            chk(iss == 0 ? "R4 chunk_len" : "R5 chunk_len", int'(chunk_len), exp_len);
            chk("R5 chunk_write", int'(chunk_write), int'(wr));
            clen = int'(chunk_len);
            iss  = iss + exp_len;
            callback(int'(chunk_key));
            chk("R6 no chunk before re-arm", int'(chunk_valid), 0);
            if (!wr) begin
                chk("R8 copy_valid", int'(copy_valid), 1);
                chk("R8 copy_buf_pos", int'(copy_buf_pos), cmp);
                chk("R8 copy_line_off", int'(copy_line_off), (cmp == 0) ? off : 0);
                chk("R8 copy_len", int'(copy_len), exp_len);
            end else begin
                chk("R8 no copy on write", int'(copy_valid), 0);
            end
            cmp = iss;
            if (cmp == len) begin
                chk("R7 done_valid", int'(done_valid), 1);
                chk("R7 done_addr", int'(done_addr), addr);
                chk("R7 done_len", int'(done_len), len);
                chk("R7 done_write", int'(done_write), int'(wr));
                chk("R7 count", int'(outstanding), 0);
                chk("R10 idle", int'(busy), 0);
            end else begin
                chk("R7 no early done", int'(done_valid), 0);
            end
        end
        if (clen < 0) chk("R5 chunk length sign", clen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset busy", int'(busy), 0);
        chk("R10 reset count", int'(outstanding), 0);
        chk("R10 reset adm", int'(adm_valid), 0);
        chk("R10 reset chunk", int'(chunk_valid), 0);
        chk("R10 reset done", int'(done_valid), 0);
        chk("R10 reset err", int'(cb_err), 0);

        // sweep every in-line offset and lengths up to three lines
        for (int off = 0; off < LINE; off++) begin
            for (int len = 1; len <= 20; len++) begin
                run_xfer(12'h200 + off, len, bit'(len % 2));
            end
        end

        // fill the table
        send(12'h080, 16, 1'b0); chk("R3 A ok", int'(adm_code), 0);
        send(12'h100, 16, 1'b1); chk("R3 B ok", int'(adm_code), 0);
        send(12'h180, 16, 1'b0); chk("R3 C ok", int'(adm_code), 0);
        send(12'h200, 16, 1'b1); chk("R3 D ok", int'(adm_code), 0);
        chk("R10 count 4", int'(outstanding), 4);
        send(12'h280, 8, 1'b0);
        chk("R1 full code", int'(adm_code), 1);
        chk("R1 full count", int'(outstanding), 4);
        send(12'h080, 8, 1'b0);
        chk("R1 full beats alias", int'(adm_code), 1);
        repeat (3) @(negedge clk);

        callback(12'h080 >> OFFW);
        chk("R8 fill copy", int'(copy_valid), 1);
        chk("R7 not yet done", int'(done_valid), 0);
        @(negedge clk);
        chk("R6 second chunk", int'(chunk_valid), 1);
        chk("R5 second addr", int'(chunk_addr), 12'h088);
        chk("R5 second len", int'(chunk_len), 8);
        callback(12'h080 >> OFFW);
        chk("R7 fill done", int'(done_valid), 1);
        chk("R7 fill done addr", int'(done_addr), 12'h080);
        chk("R7 fill count", int'(outstanding), 3);

        send(12'h104, 4, 1'b0);
        chk("R2 alias code", int'(adm_code), 2);
        chk("R2 alias count", int'(outstanding), 3);
        @(negedge clk);
        chk("R2 alias no chunk", int'(chunk_valid), 0);
        send(12'h084, 4, 1'b1);
        chk("R7 freed line accepted", int'(adm_code), 0);
        chk("R7 count back to 4", int'(outstanding), 4);
        repeat (2) @(negedge clk);

        callback(12'h1FF);
        chk("R9 err set", int'(cb_err), 1);
        chk("R9 count kept", int'(outstanding), 4);
        chk("R9 no done", int'(done_valid), 0);
        chk("R9 no copy", int'(copy_valid), 0);
        repeat (2) @(negedge clk);
        chk("R9 err sticky", int'(cb_err), 1);
        chk("R10 busy full", int'(busy), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule